// File: doc/BRIEF.md
# Windowed Holdover Frequency Averager

This block keeps a circular history of frequency-control words taken from a locked loop at a fixed sample tick. When the loop loses its reference, a one-cycle entry strobe asks the block for a holdover frequency. The block averages the stored words that fall inside a selectable window. The window ends a selectable guard delay before the strobe, so the words written just before the failure, which may already be corrupt, play no part in the result.

Time is counted in sample ticks. The parameter `SPS` gives ticks per second and scales every window and delay length. The history holds at least 120 seconds of ticks: its depth is 120·SPS rounded up to a power of two. The averaging walks the selected words one per clock. A sequential restoring divider then produces the quotient, and the result word is presented with a level done flag. From the strobe until the locked input rises again, no new words enter the history, so repeated requests see the same data.

Top module: `holdover_avg`

## Requirements
- R1: After a synchronous active-low reset, `hold_done` is 0, `hold_word` is 0 and the history is empty.
- R2: A word on `smp_word` is stored only in a cycle where `smp_valid` is 1, `locked` is 1, the history is not frozen and `hold_enter` is 0. Words offered while `locked` is 0 are not stored.
- R3: `win_sel` picks the window length in ticks: 0 → 1·SPS, 1 → 10·SPS, 2 → 30·SPS, 3 → 60·SPS.
- R4: `dly_sel` picks the guard delay as ceil(ms·SPS/1000) ticks, with ms = 0, 30, 60, 1000, 10000, 30000, 60000 for codes 0 to 6. Code 7 behaves like code 6.
- R5: Number the stored words by age, with 0 for the newest. The result is floor(sum/n) of the words with ages d to d+n−1, where d is the delay in ticks. Words are unsigned.
- R6: With F stored words and window W ticks, n = min(W, F−d) when F > d, and 0 otherwise.
- R7: When n is 0, `hold_word` takes the last word accepted with `smp_valid` while not frozen (whether or not `locked` was 1), or 0 if there is none. `hold_done` is 1 in the cycle after the strobe.
- R8: After a strobe, the history is frozen, and offered words change neither the stored data nor the last accepted word. A rising edge of `locked` re-arms storage.
- R9: A strobe accepted with n > 0 clears `hold_done` at that edge. `hold_done` returns to 1 once the quotient is ready. While `hold_done` stays 1 and no strobe arrives, `hold_word` holds its value.
- R10: A strobe that arrives while a computation is running is ignored, and the running result is unaffected.
- R11: Once more than the history depth has been stored, the oldest words are overwritten and the fill count saturates at the depth. Averages are still taken over the newest words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample tick: `smp_word` is offered this cycle |
| smp_word | input | DW | Frequency-control word from the loop |
| locked | input | 1 | Loop lock qualifier; its rising edge re-arms storage |
| win_sel | input | 2 | Averaging window select |
| dly_sel | input | 3 | Guard delay select |
| hold_enter | input | 1 | One-cycle holdover entry strobe |
| hold_word | output | DW | Averaged holdover frequency word |
| hold_done | output | 1 | Result valid |

## Verification
A wrong write pointer or fill count does not show at the ports until the next entry strobe. It then shows as a changed average, because the window shifts or shrinks by the amount of the error. A fault in freeze or re-arm shows as a second request returning a different word over unchanged history. A slip in the read pipeline or in a divider step corrupts every result by one word or one bit, and this is visible as soon as `hold_done` rises. A stuck state machine shows as `hold_done` never rising.

// File: rtl/hoa_pkg.sv
// Shared types and length decoders for the holdover averager.
// Assumes window and delay codes are decoded against a ticks-per-second value.
package hoa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SUM  = 2'd1,
        ST_DIV  = 2'd2
    } avg_state_e;

    // Window length in ticks for a window select code.
    function automatic int unsigned win_len(input logic [1:0] sel, input int unsigned sps);
        case (sel)
            2'd0:    return sps;
            2'd1:    return 10 * sps;
            2'd2:    return 30 * sps;
            default: return 60 * sps;
        endcase
    endfunction

    // Guard delay in ticks for a delay select code, rounded up.
    function automatic int unsigned guard_len(input logic [2:0] sel, input int unsigned sps);
        int unsigned ms;
        case (sel)
            3'd0:    ms = 0;
            3'd1:    ms = 30;
            3'd2:    ms = 60;
            3'd3:    ms = 1000;
            3'd4:    ms = 10000;
            3'd5:    ms = 30000;
            default: ms = 60000;
        endcase
        return (ms * sps + 999) / 1000;
    endfunction

endpackage

// File: rtl/hoa_history.sv
// Circular history of frequency words with freeze and re-arm control.
// Assumes DEPTH is a power of two, 2**PW. Stores only while locked and not
// frozen. A strobe freezes storage, and a rising edge of locked releases it.
module hoa_history #(
    parameter int DW    = 20,
    parameter int DEPTH = 4096,
    parameter int PW    = 12,
    parameter int CW    = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_word,
    input  logic          locked,
    input  logic          hold_enter,
    input  logic [PW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [PW-1:0] wr_ptr,
    output logic [CW-1:0] fill,
    output logic          frozen,
    output logic [DW-1:0] last_raw
);

    logic [DW-1:0] mem [DEPTH];
    logic          locked_q;
    logic          take;
    logic          store;

    assign take  = smp_valid && !frozen && !hold_enter;
    assign store = take && locked;

    // Write an accepted word into the ring.
    always_ff @(posedge clk) begin
        if (store) begin
            mem[wr_ptr] <= smp_word;
        end
    end

    // Registered read port for the averaging walk.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end

    // Pointer, fill, freeze and last-word bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            fill     <= '0;
            frozen   <= 1'b0;
            locked_q <= 1'b0;
            last_raw <= '0;
        end else begin
            locked_q <= locked;
            if (hold_enter) begin
                frozen <= 1'b1;
            end else if (locked && !locked_q) begin
                frozen <= 1'b0;
            end
            if (store) begin
                wr_ptr <= wr_ptr + PW'(1);
                if (fill != CW'(DEPTH)) begin
                    fill <= fill + CW'(1);
                end
            end
            if (take) begin
                last_raw <= smp_word;
            end
        end
    end

endmodule

// File: rtl/hoa_divider.sv
// Sequential restoring divider: SW quotient bits, one per cycle after start.
// Assumes a nonzero divisor no wider than the dividend. done pulses once.
module hoa_divider #(
    parameter int SW = 31,
    parameter int QW = 20,
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] dividend,
    input  logic [CW-1:0] divisor,
    output logic          done,
    output logic [QW-1:0] quotient
);

    localparam int SCW = $clog2(SW + 1);

    logic [SW-1:0]  rem_q;
    logic [SW-1:0]  quo_q;
    logic [SW-1:0]  dvs_q;
    logic [SCW-1:0] step_q;
    logic           run_q;
    logic [SW:0]    trial;
    logic           fits;

    // Shift the next dividend bit into the partial remainder and compare.
    always_comb begin
        trial = {rem_q, quo_q[SW-1]};
        fits  = trial >= {1'b0, dvs_q};
    end

    // One restoring step per cycle until all quotient bits are formed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dvs_q  <= SW'(divisor);
                step_q <= SCW'(SW);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q  <= fits ? SW'(trial - {1'b0, dvs_q}) : trial[SW-1:0];
                quo_q  <= {quo_q[SW-2:0], fits};
                step_q <= step_q - SCW'(1);
                if (step_q == SCW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q[QW-1:0];

endmodule

// File: rtl/holdover_avg.sv
// Windowed holdover frequency averager (top).
// Assumes one sample per tick at SPS ticks per second, and unsigned words.
// On a strobe it averages the words aged d..d+n-1, where d is the guard
// delay, walking the words one per cycle and then dividing sequentially.
module holdover_avg #(
    parameter int DW  = 20,
    parameter int SPS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_word,
    input  logic          locked,
    input  logic [1:0]    win_sel,
    input  logic [2:0]    dly_sel,
    input  logic          hold_enter,
    output logic [DW-1:0] hold_word,
    output logic          hold_done
);
    import hoa_pkg::*;

    localparam int DEPTH = 1 << $clog2(120 * SPS);
    localparam int PW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int WMAX  = 60 * SPS;
    localparam int SW    = DW + $clog2(WMAX + 1);

    logic [PW-1:0] wptr;
    logic [CW-1:0] fill;
    logic          frz;
    logic [DW-1:0] last_raw;
    logic [DW-1:0] rd_data;
    logic [PW-1:0] rd_addr_q;

    logic [CW-1:0] w_len;
    logic [CW-1:0] d_len;
    logic [CW-1:0] span;
    logic [CW-1:0] n_eff;
    logic [PW-1:0] start_addr;

    avg_state_e    st_q;
    logic [CW-1:0] remain_q;
    logic          pend_q;
    logic [SW-1:0] acc_q;
    logic [CW-1:0] n_lat;
    logic          div_start;
    logic          div_done;
    logic [DW-1:0] quotient;
    logic [DW-1:0] word_q;
    logic          done_q;

    hoa_history #(.DW(DW), .DEPTH(DEPTH), .PW(PW), .CW(CW)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_word   (smp_word),
        .locked     (locked),
        .hold_enter (hold_enter),
        .rd_addr    (rd_addr_q),
        .rd_data    (rd_data),
        .wr_ptr     (wptr),
        .fill       (fill),
        .frozen     (frz),
        .last_raw   (last_raw)
    );

    hoa_divider #(.SW(SW), .QW(DW), .CW(CW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (acc_q),
        .divisor  (n_lat),
        .done     (div_done),
        .quotient (quotient)
    );

    // Decode the selects and clip the window to the words actually present.
    always_comb begin
        w_len = CW'(win_len(win_sel, SPS));
        d_len = CW'(guard_len(dly_sel, SPS));
        span  = '0;
        n_eff = '0;
        if (fill > d_len) begin
            span  = fill - d_len;
            n_eff = (span < w_len) ? span : w_len;
        end
        start_addr = wptr - PW'(1) - d_len[PW-1:0];
    end

    // Sequence the request: accept, walk and sum, divide, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            rd_addr_q <= '0;
            remain_q  <= '0;
            pend_q    <= 1'b0;
            acc_q     <= '0;
            n_lat     <= '0;
            div_start <= 1'b0;
            word_q    <= '0;
            done_q    <= 1'b0;
        end else begin
            div_start <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (hold_enter) begin
                        if (n_eff == '0) begin
                            word_q <= last_raw;
                            done_q <= 1'b1;
                        end else begin
                            done_q    <= 1'b0;
                            n_lat     <= n_eff;
                            remain_q  <= n_eff;
                            rd_addr_q <= start_addr;
                            acc_q     <= '0;
                            pend_q    <= 1'b0;
                            st_q      <= ST_SUM;
                        end
                    end
                end
                ST_SUM: begin
                    if (remain_q != '0) begin
                        rd_addr_q <= rd_addr_q - PW'(1);
                        remain_q  <= remain_q - CW'(1);
                    end
                    pend_q <= (remain_q != '0);
                    if (pend_q) begin
                        acc_q <= acc_q + SW'(rd_data);
                    end
                    if (remain_q == '0 && !pend_q) begin
                        st_q      <= ST_DIV;
                        div_start <= 1'b1;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        word_q <= quotient;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign hold_word = word_q;
    assign hold_done = done_q;

endmodule

// File: rtl/hoa_checker.sv
// Temporal checks on the holdover averager, attached by bind.
// Assumes it observes the top's ports and its sequencing state.
module hoa_checker #(
    parameter int DW    = 20,
    parameter int CW    = 13,
    parameter int PW    = 12,
    parameter int DEPTH = 4096
) (
    input logic                clk,
    input logic                rst_n,
    input logic                locked,
    input logic                hold_enter,
    input logic                hold_done,
    input logic [DW-1:0]       hold_word,
    input hoa_pkg::avg_state_e st,
    input logic [CW-1:0]       n_eff,
    input logic [CW-1:0]       n_lat,
    input logic [CW-1:0]       fill,
    input logic [PW-1:0]       wr_ptr,
    input logic                frozen
);
    import hoa_pkg::*;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!hold_done && hold_word == '0));

    // R2
    no_store_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!locked) |-> ($stable(fill) && $stable(wr_ptr)));

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frozen) |-> $stable(wr_ptr));

    // R9
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_enter && st == ST_IDLE && n_eff != '0) |=> !hold_done);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_done && $past(hold_done) && !$past(hold_enter)) |-> $stable(hold_word));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && hold_enter) |=> $stable(n_lat));

    // R11
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

endmodule

bind holdover_avg hoa_checker #(.DW(DW), .CW(CW), .PW(PW), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .locked     (locked),
    .hold_enter (hold_enter),
    .hold_done  (hold_done),
    .hold_word  (hold_word),
    .st         (st_q),
    .n_eff      (n_eff),
    .n_lat      (n_lat),
    .fill       (fill),
    .wr_ptr     (wptr),
    .frozen     (frz)
);

// File: tb/holdover_avg_test.sv
// Bench for holdover_avg: a vector table walked by one loop, then directed cases.
module holdover_avg_test;

    localparam int DW    = 20;
    localparam int SPS   = 32;
    localparam int DEPTH = 1 << $clog2(120 * SPS);
    localparam int NV    = 9;
    // Each entry: {reset_first, win_sel, dly_sel, words_to_store, seed}
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 2'd0, 3'd0, 16'd40,   8'd1},
        {1'b0, 2'd0, 3'd1, 16'd40,   8'd2},
        {1'b0, 2'd1, 3'd2, 16'd10,   8'd3},
        {1'b1, 2'd1, 3'd3, 16'd100,  8'd4},
        {1'b0, 2'd2, 3'd4, 16'd400,  8'd5},
        {1'b0, 2'd3, 3'd5, 16'd2000, 8'd6},
        {1'b0, 2'd3, 3'd7, 16'd1500, 8'd7},
        {1'b1, 2'd0, 3'd6, 16'd30,   8'd8},
        {1'b0, 2'd2, 3'd0, 16'd0,    8'd9}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          smp_valid;
    logic [DW-1:0] smp_word;
    logic          locked;
    logic [1:0]    win_sel;
    logic [2:0]    dly_sel;
    logic          hold_enter;
    logic [DW-1:0] hold_word;
    logic          hold_done;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] hist_m [DEPTH];
    int            wp_m;
    int            cnt_m;
    logic          frz_m;
    logic [DW-1:0] raw_m;

    always #4 clk = ~clk;

    holdover_avg #(.DW(DW), .SPS(SPS)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_word   (smp_word),
        .locked     (locked),
        .win_sel    (win_sel),
        .dly_sel    (dly_sel),
        .hold_enter (hold_enter),
        .hold_word  (hold_word),
        .hold_done  (hold_done)
    );

    function automatic int win_ticks(input int sel);
        case (sel)
            0:       return SPS;
            1:       return 10 * SPS;
            2:       return 30 * SPS;
            default: return 60 * SPS;
        endcase
    endfunction

    function automatic int dly_ticks(input int sel);
        int ms;
        case (sel)
            0: ms = 0;
            1: ms = 30;
            2: ms = 60;
            3: ms = 1000;
            4: ms = 10000;
            5: ms = 30000;
            default: ms = 60000;
        endcase
        return (ms * SPS + 999) / 1000;
    endfunction

    function automatic logic [DW-1:0] pattern(input int seed, input int k);
        return DW'(seed * 7919 + k * (seed + 3) * 131 + (k * k) % 977);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n      = 1'b0;
        smp_valid  = 1'b0;
        smp_word   = '0;
        locked     = 1'b0;
        win_sel    = '0;
        dly_sel    = '0;
        hold_enter = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wp_m  = 0;
        cnt_m = 0;
        frz_m = 1'b0;
        raw_m = '0;
    endtask

    task automatic rearm();
        @(negedge clk) locked = 1'b0;
        @(negedge clk) locked = 1'b1;
        @(negedge clk);
        frz_m = 1'b0;
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_word  = v;
        if (!frz_m) begin
            raw_m = v;
            if (locked) begin
                hist_m[wp_m] = v;
                wp_m = (wp_m + 1) % DEPTH;
                if (cnt_m < DEPTH) cnt_m++;
            end
        end
    endtask

    task automatic fill_words(input int n, input int seed);
        for (int k = 0; k < n; k++) push(pattern(seed, k));
        @(negedge clk) smp_valid = 1'b0;
    endtask

    task automatic model_avg(input int w, input int d, output logic [DW-1:0] res, output int n);
        longint sum = 0;
        n = (cnt_m > d) ? ((cnt_m - d < w) ? cnt_m - d : w) : 0;
        if (n == 0) begin
            res = raw_m;
        end else begin
            for (int j = d; j < d + n; j++) sum += hist_m[(wp_m - 1 - j + 2 * DEPTH) % DEPTH];
            res = DW'(sum / n);
        end
    endtask

    task automatic wait_done();
        int t = 0;
        while (!hold_done && t < 6000) begin
            @(negedge clk);
            t++;
        end
        if (!hold_done) begin
            checks++;
            fails++;
            $display("FAIL R9 done never rose actual=0 expected=1");
        end
    endtask

    task automatic strobe(input int ws, input int ds);
        @(negedge clk);
        win_sel    = 2'(ws);
        dly_sel    = 3'(ds);
        hold_enter = 1'b1;
        @(negedge clk) hold_enter = 1'b0;
        frz_m = 1'b1;
    endtask

    task automatic run_entry(input int ws, input int ds, input string tag);
        logic [DW-1:0] exp;
        int            n;
        model_avg(win_ticks(ws), dly_ticks(ds), exp, n);
        strobe(ws, ds);
        if (n > 0) check("R9 done low after strobe", 64'(hold_done), 64'd0);
        wait_done();
        check(tag, 64'(hold_word), 64'(exp));
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] first_exp;
        int            first_n;

        do_reset();
        // R1: outputs after reset
        check("R1 done after reset", 64'(hold_done), 64'd0);
        check("R1 word after reset", 64'(hold_word), 64'd0);

        // Table walk: windows, delays, partial history, zero eligible words
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][29]) do_reset();
            rearm();
            fill_words(int'(VEC[i][23:8]), int'(VEC[i][7:0]));
            run_entry(int'(VEC[i][28:27]), int'(VEC[i][26:24]),
                      $sformatf("R3 R4 R5 R6 R7 vector %0d", i));
        end

        // R7 and R2: only unlocked words offered, so the result is the last raw word
        do_reset();
        for (int k = 0; k < 3; k++) push(pattern(21, k));
        @(negedge clk) smp_valid = 1'b0;
        run_entry(0, 0, "R7 last raw word with empty history");

        // R2: after re-arm only locked words count
        rearm();
        fill_words(5, 22);
        run_entry(0, 0, "R2 only locked words averaged");

        // R8: words offered while frozen leave the history untouched
        model_avg(win_ticks(0), dly_ticks(0), first_exp, first_n);
        fill_words(20, 23);
        run_entry(0, 0, "R8 frozen history unchanged");
        check("R8 same result as before freeze", 64'(hold_word), 64'(first_exp));

        // R10: a strobe during computation is ignored
        rearm();
        fill_words(400, 24);
        model_avg(win_ticks(1), dly_ticks(0), first_exp, first_n);
        strobe(1, 0);
        repeat (3) @(negedge clk);
        strobe(0, 3);
        wait_done();
        check("R10 busy strobe ignored", 64'(hold_word), 64'(first_exp));

        // R11: wrap past the depth, then the longest window and delay
        rearm();
        fill_words(DEPTH + 200, 25);
        run_entry(3, 6, "R11 wrapped history longest span");
        run_entry(3, 5, "R11 wrapped history saturated fill");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule